// File: doc/BRIEF.md
# Status Calendar Receive Monitor

This block watches the two-bit FIFO status channel that comes back to the data-transmit side of a SPI-4.2 link. It locks onto the framing word and walks a fixed calendar with one framing slot, one status entry for each port, and one closing parity word. It checks the parity code of every calendar cycle and decides whether the status channel can be trusted. The data path uses the result to choose between sending training patterns and sending normal traffic.

Validation needs a programmable run of consecutive good calendar cycles. A programmable run of consecutive calendar cycles made only of framing words declares loss of synchronization. A scheduler reads the per-port status (starving, hungry or satisfied). That status changes only when a cycle closes with correct parity. While the channel is not in sync, every port reads as satisfied.

Top module: `stat_cal_monitor`

## Requirements
- R1: After reset `send_training` is 1 and every port field of `port_status` reads 2'b10 (satisfied). Port i occupies bits [2i+1:2i]. The codes are 2'b00 starving, 2'b01 hungry and 2'b10 satisfied.
- R2: A calendar cycle is NUM_PORTS+2 status words: framing 2'b11, then ports 0 to NUM_PORTS-1 in order, then the parity word. While hunting, any 2'b11 is taken as the framing word. Once aligned, a non-2'b11 word in the framing slot drops alignment and clears the consecutive-good count.
- R3: The expected parity word is computed as follows. Start with acc = 2'b11. For each port entry e in port order, set acc = {acc[0], acc[1]} ^ e. The final acc is the expected parity word.
- R4: `send_training` falls at the close of the cycle that makes the consecutive-good count reach `cfg_dip2_thr`. A threshold of 0 acts as 1.
- R5: A cycle whose parity word mismatches, or a cycle made entirely of 2'b11 words, clears the consecutive-good count and never causes validation.
- R6: Port status fields take the entries of a cycle only at the close of a cycle with correct parity that is not all framing. Otherwise they hold, including while a cycle is still in progress.
- R7: While `send_training` is 1, all port fields read 2'b10.
- R8: While in sync, `cfg_los_thr` consecutive all-framing cycles raise `send_training` at the close of the last of them. Any other complete cycle resets that run. A threshold of 0 acts as 1.
- R9: After loss of sync, validation again needs a fresh run of `cfg_dip2_thr` consecutive good cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_in | input | 2 | Incoming status word |
| cfg_dip2_thr | input | CNT_W | Consecutive good cycles needed to validate |
| cfg_los_thr | input | CNT_W | Consecutive all-framing cycles that drop sync |
| send_training | output | 1 | High while the data path must send training |
| port_status | output | 2*NUM_PORTS | Per-port status, two bits per port |

## Verification
The closing parity word of a cycle does two jobs on the same clock edge: it can complete validation, and it captures the port status that becomes visible at that moment. The vector table provokes this by letting the threshold-reaching good cycle carry a fresh status pattern. The bench then samples `send_training` and `port_status` together just after that edge, expecting the new pattern, not the previous one or all-satisfied. Loss of sync and the forced all-satisfied view also share an edge, and the bench judges both on the same sample.

// File: rtl/stat_cal_pkg.sv
package stat_cal_pkg;

   typedef enum logic [1:0] {
      PST_STARVE    = 2'b00,
      PST_HUNGRY    = 2'b01,
      PST_SATISFIED = 2'b10,
      PST_FRAME     = 2'b11
   } port_stat_e;

   // one step of the diagonal parity: rotate, then fold in the entry
   function automatic logic [1:0] dip_step(input logic [1:0] acc, input logic [1:0] ent);
      return {acc[0], acc[1]} ^ ent;
   endfunction

endpackage

// File: rtl/sts_frame_track.sv
module sts_frame_track
   import stat_cal_pkg::*;
#(
   parameter int NUM_PORTS = 10,
   localparam int PH_W  = $clog2(NUM_PORTS + 2),
   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       stat_in,
   output logic             at_frm,
   output logic             at_port,
   output logic             at_dip,
   output logic [IDX_W-1:0] port_idx,
   output logic             dip_match,
   output logic             all_frame,
   output logic             slip
);
   localparam logic [PH_W-1:0] PH_DIP = PH_W'(NUM_PORTS + 1);

   logic            aligned;
   logic [PH_W-1:0] phase;
   logic [1:0]      acc;
   logic            frm_all;

   assign at_frm    = aligned && (phase == '0);
   assign at_dip    = aligned && (phase == PH_DIP);
   assign at_port   = aligned && !at_frm && !at_dip;
   assign port_idx  = IDX_W'(phase - PH_W'(1));
   assign dip_match = at_dip && (stat_in == acc);
   assign all_frame = at_dip && frm_all && (stat_in == PST_FRAME);
   assign slip      = at_frm && (stat_in != PST_FRAME);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aligned <= 1'b0;
         phase   <= '0;
         acc     <= 2'b11;
         frm_all <= 1'b1;
      end else if (!aligned || at_frm) begin
         if (stat_in == PST_FRAME) begin
            aligned <= 1'b1;
            phase   <= PH_W'(1);
            acc     <= 2'b11;
            frm_all <= 1'b1;
         end else begin
            aligned <= 1'b0;
            phase   <= '0;
         end
      end else if (at_port) begin
         acc     <= dip_step(acc, stat_in);
         frm_all <= frm_all && (stat_in == PST_FRAME);
         phase   <= phase + PH_W'(1);
      end else begin
         phase <= '0;
      end
   end
endmodule

// File: rtl/sts_sync_ctl.sv
module sts_sync_ctl #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             at_dip,
   input  logic             dip_match,
   input  logic             all_frame,
   input  logic             slip,
   input  logic [CNT_W-1:0] cfg_dip2_thr,
   input  logic [CNT_W-1:0] cfg_los_thr,
   output logic             synced,
   output logic             cap_en
);
   logic [CNT_W-1:0] good_cnt;
   logic [CNT_W-1:0] los_cnt;
   logic [CNT_W:0]   good_inc;
   logic [CNT_W:0]   los_inc;
   logic             good_cyc;
   logic             good_hit;
   logic             los_hit;

   assign good_cyc = dip_match && !all_frame;
   assign cap_en   = at_dip && good_cyc;
   assign good_inc = {1'b0, good_cnt} + (CNT_W+1)'(1);
   assign los_inc  = {1'b0, los_cnt} + (CNT_W+1)'(1);
   assign good_hit = good_inc >= {1'b0, cfg_dip2_thr};
   assign los_hit  = los_inc >= {1'b0, cfg_los_thr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_cnt <= '0;
         los_cnt  <= '0;
         synced   <= 1'b0;
      end else if (slip) begin
         good_cnt <= '0;
      end else if (at_dip) begin
         if (good_cyc) begin
            good_cnt <= good_inc[CNT_W] ? good_cnt : good_inc[CNT_W-1:0];
            if (good_hit) synced <= 1'b1;
         end else begin
            good_cnt <= '0;
         end
         if (all_frame) begin
            if (synced && los_hit) begin
               synced  <= 1'b0;
               los_cnt <= '0;
            end else begin
               los_cnt <= los_inc[CNT_W] ? los_cnt : los_inc[CNT_W-1:0];
            end
         end else begin
            los_cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/sts_port_store.sv
module sts_port_store
   import stat_cal_pkg::*;
#(
   parameter int NUM_PORTS = 10,
   parameter int IDX_W     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             stat_in,
   input  logic                   at_port,
   input  logic [IDX_W-1:0]       port_idx,
   input  logic                   cap_en,
   input  logic                   synced,
   output logic [2*NUM_PORTS-1:0] port_status
);
   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      logic [1:0] shadow;
      logic [1:0] held;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow <= PST_SATISFIED;
            held   <= PST_SATISFIED;
         end else begin
            if (at_port && (port_idx == IDX_W'(i))) shadow <= stat_in;
            if (cap_en) held <= shadow;
         end
      end

      assign port_status[2*i +: 2] = synced ? held : PST_SATISFIED;
   end
endmodule

// File: rtl/stat_cal_monitor.sv
module stat_cal_monitor #(
   parameter int NUM_PORTS = 10,
   parameter int CNT_W     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             stat_in,
   input  logic [CNT_W-1:0]       cfg_dip2_thr,
   input  logic [CNT_W-1:0]       cfg_los_thr,
   output logic                   send_training,
   output logic [2*NUM_PORTS-1:0] port_status
);
   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   if (NUM_PORTS < 1 || NUM_PORTS > 256) begin : g_bad_ports
      $error("stat_cal_monitor: NUM_PORTS out of range");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("stat_cal_monitor: CNT_W out of range");
   end

   logic             at_frm;
   logic             at_port;
   logic             at_dip;
   logic [IDX_W-1:0] port_idx;
   logic             dip_match;
   logic             all_frame;
   logic             slip;
   logic             synced;
   logic             cap_en;

   sts_frame_track #(.NUM_PORTS(NUM_PORTS)) u_frm (
      .clk(clk), .rst_n(rst_n), .stat_in(stat_in),
      .at_frm(at_frm), .at_port(at_port), .at_dip(at_dip),
      .port_idx(port_idx), .dip_match(dip_match),
      .all_frame(all_frame), .slip(slip)
   );

   sts_sync_ctl #(.CNT_W(CNT_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .at_dip(at_dip),
      .dip_match(dip_match), .all_frame(all_frame), .slip(slip),
      .cfg_dip2_thr(cfg_dip2_thr), .cfg_los_thr(cfg_los_thr),
      .synced(synced), .cap_en(cap_en)
   );

   sts_port_store #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .stat_in(stat_in),
      .at_port(at_port), .port_idx(port_idx), .cap_en(cap_en),
      .synced(synced), .port_status(port_status)
   );

   assign send_training = !synced;
endmodule

// File: rtl/stat_cal_monitor_chk.sv
module stat_cal_monitor_chk #(
   parameter int NUM_PORTS = 10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   send_training,
   input logic [2*NUM_PORTS-1:0] port_status,
   input logic                   at_dip,
   input logic                   at_frm,
   input logic                   dip_match,
   input logic                   cap_en,
   input logic                   all_frame
);
   localparam logic [2*NUM_PORTS-1:0] ALL_SAT = {NUM_PORTS{2'b10}};

   p_lost_all_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      send_training |-> (port_status == ALL_SAT));

   p_lock_needs_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(send_training) |-> $past(cap_en));

   p_loss_needs_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(send_training) |-> $past(all_frame));

   p_hold_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en && !send_training) |=> (send_training || $stable(port_status)));

   p_dip_then_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      at_dip |=> at_frm);

   p_bad_no_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (at_dip && !dip_match) |=> !$fell(send_training));
endmodule

bind stat_cal_monitor stat_cal_monitor_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .send_training(send_training),
   .port_status(port_status), .at_dip(at_dip), .at_frm(at_frm),
   .dip_match(dip_match), .cap_en(cap_en), .all_frame(all_frame)
);

// File: tb/sim_stat_cal_monitor.sv
`timescale 1ns/1ps
module sim_stat_cal_monitor;
   localparam int NP = 10;
   localparam logic [2*NP-1:0] ALL_SAT = {NP{2'b10}};
   localparam int K_GOOD = 0;
   localparam int K_BAD  = 1;
   localparam int K_FRM  = 2;

   // {kind[1:0], expected send_training, ports[19:0]}
   localparam logic [22:0] TAB [12] = '{
      {2'd0, 1'b1, 20'h12456},
      {2'd0, 1'b0, 20'h89A01},
      {2'd1, 1'b0, 20'h65421},
      {2'd0, 1'b0, 20'hA0A0A},
      {2'd2, 1'b0, 20'h00000},
      {2'd0, 1'b0, 20'h55555},
      {2'd2, 1'b0, 20'h00000},
      {2'd2, 1'b1, 20'h00000},
      {2'd0, 1'b1, 20'h02468},
      {2'd1, 1'b1, 20'h98612},
      {2'd0, 1'b1, 20'h4A1A2},
      {2'd0, 1'b0, 20'h21098}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    stat_in = 2'b00;
   logic [3:0]    cfg_dip2_thr = 4'd1;
   logic [3:0]    cfg_los_thr = 4'd3;
   logic          send_training;
   logic [2*NP-1:0] port_status;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   stat_cal_monitor u0 (
      .clk(clk), .rst_n(rst_n), .stat_in(stat_in),
      .cfg_dip2_thr(cfg_dip2_thr), .cfg_los_thr(cfg_los_thr),
      .send_training(send_training), .port_status(port_status)
   );

   function automatic logic [1:0] exp_dip(input logic [2*NP-1:0] p);
      logic [1:0] a = 2'b11;
      for (int i = 0; i < NP; i++) a = {a[0], a[1]} ^ p[2*i +: 2];
      return a;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [1:0] w);
      @(negedge clk);
      stat_in = w;
   endtask

   task automatic send_cycle(input int kind, input logic [2*NP-1:0] p);
      put(2'b11);
      for (int i = 0; i < NP; i++) put(kind == K_FRM ? 2'b11 : p[2*i +: 2]);
      if (kind == K_FRM)      put(2'b11);
      else if (kind == K_BAD) put(exp_dip(p) ^ 2'b01);
      else                    put(exp_dip(p));
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input logic [3:0] thr, input logic [3:0] los);
      stat_in = 2'b00;
      cfg_dip2_thr = thr;
      cfg_los_thr = los;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [2*NP-1:0] last_good;
      // R1: reset state
      do_reset(4'd2, 4'd2);
      @(posedge clk); #1;
      chk("R1 training", 32'(send_training), 32'd1);
      chk("R1 status", 32'(port_status), 32'(ALL_SAT));

      // table walk, thr=2, los=2 (R3 R4 R5 R6 R7 R8 R9)
      last_good = ALL_SAT;
      for (int r = 0; r < 12; r++) begin
         int kind;
         logic [2*NP-1:0] p;
         logic etr;
         string tt;
         string ts;
         kind = int'(TAB[r][22:21]);
         etr  = TAB[r][20];
         p    = TAB[r][19:0];
         send_cycle(kind, p);
         if (kind == K_GOOD) last_good = p;
         tt = (r >= 8) ? "R9 training" : (kind == K_FRM) ? "R8 training" :
              (kind == K_BAD) ? "R5 training" : "R3 R4 training";
         ts = etr ? "R7 status" : "R6 status";
         chk(tt, 32'(send_training), 32'(etr));
         chk(ts, 32'(port_status), 32'(etr ? ALL_SAT : last_good));
      end

      // R6: entries of a cycle in progress are not visible before its close
      send_cycle(K_GOOD, 20'h11111);
      chk("R6 sync kept", 32'(send_training), 32'd0);
      put(2'b11);
      for (int i = 0; i < NP; i++) put(2'b00);
      @(posedge clk); #1;
      chk("R6 mid cycle hold", 32'(port_status), 32'h11111);
      put(exp_dip(20'h00000));
      @(posedge clk); #1;
      chk("R6 close update", 32'(port_status), 32'h00000);

      // R4: threshold 1 and threshold 0 both validate after one good cycle
      do_reset(4'd1, 4'd3);
      send_cycle(K_GOOD, 20'h24680);
      chk("R4 thr1", 32'(send_training), 32'd0);
      chk("R4 thr1 status", 32'(port_status), 32'h24680);
      do_reset(4'd0, 4'd3);
      send_cycle(K_GOOD, 20'h86420);
      chk("R4 thr0", 32'(send_training), 32'd0);

      // R8: los threshold 0 acts as 1
      do_reset(4'd1, 4'd0);
      send_cycle(K_GOOD, 20'h01245);
      send_cycle(K_FRM, 20'h00000);
      chk("R8 los0", 32'(send_training), 32'd1);

      // R2: a wrong framing slot drops alignment and clears the good run
      do_reset(4'd2, 4'd3);
      send_cycle(K_GOOD, 20'h45A12);
      put(2'b01);
      send_cycle(K_GOOD, 20'h45A12);
      chk("R2 slip clears run", 32'(send_training), 32'd1);
      send_cycle(K_GOOD, 20'h9A046);
      chk("R2 realigned lock", 32'(send_training), 32'd0);
      chk("R2 realigned status", 32'(port_status), 32'h9A046);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule